// File: doc/BRIEF.md
# Interlocked Byte Handshake Port

This block moves bytes across an 8-bit parallel port using two strobe wires whose roles depend on a direction select. In output mode the port drives the data pins and an active-low data-available strobe, and the far end answers on a ready line. In input mode the roles swap: the far end drives the data-available strobe, and the port answers on its own ready output. Every edge on one wire is answered by an edge on the other wire, so neither side can overrun the other.

On the core side, outbound bytes arrive on a valid/ready stream and inbound bytes leave on a second valid/ready stream. Both external strobe inputs pass through a synchronizer of `SYNC_STAGES` flops before any decision is made on them. A change on an external strobe therefore takes effect `SYNC_STAGES + 1` clock edges later, which is 3 with the default setting. In input mode the port keeps its ready output low until the core has taken the byte, which holds back the sender. The direction select may only change while both sides are idle.

The transmit state machine has four states. TX_IDLE goes to TX_SETUP when a byte is accepted. TX_SETUP goes to TX_WAIT_LO after one cycle, and in doing so lowers the data-available strobe. TX_WAIT_LO goes to TX_WAIT_HI when the synchronized ready goes low, and in doing so raises the strobe. TX_WAIT_HI goes to TX_IDLE when the synchronized ready goes high. The receive state machine has three states. RX_IDLE goes to RX_FULL on a synchronized falling data-available strobe and latches the pins. From RX_FULL, a byte taken by the core leads to RX_IDLE if the strobe has already risen, and to RX_WAIT_DAV if it is still low. RX_WAIT_DAV goes to RX_IDLE when the strobe rises.

Top module: `hs_port_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, `dav_n_out` is 1, `rdy_out` is 1 and `rx_valid` is 0.
- R2: In output mode, `tx_ready` is 1 only in TX_IDLE while the synchronized `rdy_in` is high. A byte accepted on the core stream appears on `pin_dout` after the accepting edge.
- R3: `pin_dout` carries the accepted byte for one full cycle with `dav_n_out` high. `dav_n_out` then falls on the next edge.
- R4: While `dav_n_out` is low, it rises exactly 3 edges after `rdy_in` falls, and not before.
- R5: After `rdy_in` falls, `tx_ready` stays 0 until 3 edges after `rdy_in` has risen again, and becomes 1 at that edge.
- R6: `pin_dout` does not change while `dav_n_out` is low.
- R7: In input mode, `rdy_out` falls exactly 3 edges after `dav_n_in` falls. At that same edge `rx_valid` becomes 1, and `rx_data` equals the byte that was on `pin_din` at that edge.
- R8: Once a byte has been latched, `rdy_out` stays 0 and `rx_data` is held until the core takes the byte, whatever `dav_n_in` and `pin_din` do in the meantime.
- R9: `rdy_out` returns to 1 only when the byte has been taken and the synchronized `dav_n_in` is high. If `dav_n_in` rises after the byte is taken, `rdy_out` rises 3 edges after `dav_n_in` rises.
- R10: Strobes belonging to the mode that is not selected are ignored. In input mode `tx_ready` is 0 and `dav_n_out` is 1. In output mode `rx_valid` is 0 and `rdy_out` is 1, even while `dav_n_in` is low.
- R11: `pin_oe` equals `dir_out`, where 1 selects output mode and 0 selects input mode.
- R12: `rx_valid` falls on the edge where `rx_valid` and `rx_ready` are both 1, so each byte is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | 1 selects output mode, 0 selects input mode |
| tx_data | input | 8 | Outbound byte from the core |
| tx_valid | input | 1 | Outbound byte is valid |
| tx_ready | output | 1 | Port accepts the outbound byte |
| rx_data | output | 8 | Inbound byte to the core |
| rx_valid | output | 1 | Inbound byte is valid |
| rx_ready | input | 1 | Core takes the inbound byte |
| pin_din | input | 8 | Data pins as read |
| pin_dout | output | 8 | Data pins as driven |
| pin_oe | output | 1 | Output enable for the data pins |
| dav_n_in | input | 1 | Data-available strobe from the sender (input mode) |
| dav_n_out | output | 1 | Data-available strobe to the receiver (output mode) |
| rdy_in | input | 1 | Ready from the receiver (output mode) |
| rdy_out | output | 1 | Ready to the sender (input mode) |

## Verification
The assertions check on every cycle the properties that do not depend on latency. Data stays stable around and under a low data-available strobe. A latched byte is held while it waits for the core, and it is dropped once taken. Ready only rises once the synchronized strobe is high. The strobes of the mode that is not selected stay quiet. The exact number of edges through the synchronizer can only be shown by the bench's scenarios. The same holds for the accept-to-strobe spacing and for both orders of consuming and strobe release. The bench sweeps all 256 byte values in each direction with varying hold and consume delays.

// File: rtl/hs_pkg.sv
package hs_pkg;
    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SETUP,
        TX_WAIT_LO,
        TX_WAIT_HI
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_FULL,
        RX_WAIT_DAV
    } rx_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[i] <= RST_VAL;
                end else begin
                    pipe[i] <= (i == 0) ? d : pipe[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hs_tx_fsm.sv
module hs_tx_fsm
    import hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              rdy_s,
    output logic [DATA_W-1:0] pin_dout,
    output logic              dav_n
);
    tx_state_t         state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              accept;

    assign accept = tx_valid && tx_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) data_q <= tx_data;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:    if (accept) state_d = TX_SETUP;
            TX_SETUP:   state_d = TX_WAIT_LO;
            TX_WAIT_LO: if (!rdy_s) state_d = TX_WAIT_HI;
            TX_WAIT_HI: if (rdy_s) state_d = TX_IDLE;
            default:    state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_ready = 1'b0;
        dav_n    = 1'b1;
        unique case (state_q)
            TX_IDLE:    tx_ready = enable && rdy_s;
            TX_SETUP:   dav_n = 1'b1;
            TX_WAIT_LO: dav_n = 1'b0;
            TX_WAIT_HI: dav_n = 1'b1;
            default:    dav_n = 1'b1;
        endcase
    end

    assign pin_dout = data_q;

    assert_setup_before_dav_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dav_n) |-> $stable(pin_dout));

    assert_data_stable_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dav_n && $past(!dav_n)) |-> $stable(pin_dout));
endmodule

// File: rtl/hs_rx_fsm.sv
module hs_rx_fsm
    import hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DATA_W-1:0] pin_din,
    input  logic              dav_s,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              rdy
);
    rx_state_t         state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              dav_prev;
    logic              dav_fall;

    assign dav_fall = dav_prev && !dav_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RX_IDLE;
            data_q   <= '0;
            dav_prev <= 1'b1;
        end else begin
            state_q  <= state_d;
            dav_prev <= dav_s;
            if (state_q == RX_IDLE && enable && dav_fall) data_q <= pin_din;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:     if (enable && dav_fall) state_d = RX_FULL;
            RX_FULL:     if (rx_ready) state_d = dav_s ? RX_IDLE : RX_WAIT_DAV;
            RX_WAIT_DAV: if (dav_s) state_d = RX_IDLE;
            default:     state_d = RX_IDLE;
        endcase
    end

    always_comb begin
        rdy      = 1'b1;
        rx_valid = 1'b0;
        unique case (state_q)
            RX_IDLE:     rdy = 1'b1;
            RX_FULL:     begin rdy = 1'b0; rx_valid = 1'b1; end
            RX_WAIT_DAV: rdy = 1'b0;
            default:     rdy = 1'b1;
        endcase
    end

    assign rx_data = data_q;

    assert_latch_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> (rx_data == $past(pin_din)));

    assert_hold_until_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && !rdy && $stable(rx_data)));

    assert_rdy_after_dav_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> dav_s);

    assert_single_delivery_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> !rx_valid);
endmodule

// File: rtl/hs_port_ctrl.sv
module hs_port_ctrl #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_out,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] pin_din,
    output logic [DATA_W-1:0] pin_dout,
    output logic              pin_oe,
    input  logic              dav_n_in,
    output logic              dav_n_out,
    input  logic              rdy_in,
    output logic              rdy_out
);
    logic dav_s;
    logic rdy_s;

    hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dav (
        .clk(clk), .rst_n(rst_n), .d(dav_n_in), .q(dav_s)
    );

    hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rdy (
        .clk(clk), .rst_n(rst_n), .d(rdy_in), .q(rdy_s)
    );

    hs_tx_fsm #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .enable(dir_out),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rdy_s(rdy_s), .pin_dout(pin_dout), .dav_n(dav_n_out)
    );

    hs_rx_fsm #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .enable(!dir_out),
        .pin_din(pin_din), .dav_s(dav_s),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rdy(rdy_out)
    );

    assign pin_oe = dir_out;

    assert_input_mode_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_out |-> (dav_n_out && !tx_ready));

    assert_output_mode_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dir_out |-> (rdy_out && !rx_valid));
endmodule

// File: tb/hs_port_ctrl_test.sv
module hs_port_ctrl_test;
    localparam int LAT = 3; // synchronizer stages + 1 decision edge

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_out = 1'b1;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic [7:0] pin_din = '0;
    logic [7:0] pin_dout;
    logic       pin_oe;
    logic       dav_n_in = 1'b1;
    logic       dav_n_out;
    logic       rdy_in = 1'b1;
    logic       rdy_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    hs_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dir_out(dir_out),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .pin_din(pin_din), .pin_dout(pin_dout), .pin_oe(pin_oe),
        .dav_n_in(dav_n_in), .dav_n_out(dav_n_out),
        .rdy_in(rdy_in), .rdy_out(rdy_out)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic out_xfer(input logic [7:0] b, input int hold);
        tx_data  = b;
        tx_valid = 1'b1;
        chk(tx_ready == 1'b1, "R2 tx_ready idle", 32'(tx_ready), 1);
        step();
        tx_valid = 1'b0;
        tx_data  = ~b;
        chk(pin_dout == b, "R2 pin_dout", 32'(pin_dout), 32'(b));
        chk(dav_n_out == 1'b1, "R3 dav high in setup", 32'(dav_n_out), 1);
        step();
        chk(dav_n_out == 1'b0, "R3 dav falls", 32'(dav_n_out), 0);
        chk(pin_dout == b, "R6 data under dav", 32'(pin_dout), 32'(b));
        for (int k = 0; k < hold; k++) begin
            step();
            chk(dav_n_out == 1'b0 && pin_dout == b, "R6 hold", {23'd0, dav_n_out, pin_dout}, 32'(b));
        end
        rdy_in = 1'b0;
        for (int k = 1; k <= LAT; k++) begin
            step();
            chk(dav_n_out == (k == LAT), "R4 dav rise latency", 32'(dav_n_out), 32'(k == LAT));
        end
        for (int k = 0; k < 2; k++) begin
            chk(tx_ready == 1'b0, "R5 no accept while rdy low", 32'(tx_ready), 0);
            step();
        end
        rdy_in = 1'b1;
        for (int k = 1; k <= LAT; k++) begin
            step();
            chk(tx_ready == (k == LAT), "R5 restart latency", 32'(tx_ready), 32'(k == LAT));
        end
    endtask

    task automatic in_xfer(input logic [7:0] b, input int c, input logic consume_first);
        pin_din  = b;
        dav_n_in = 1'b0;
        for (int k = 1; k <= LAT; k++) begin
            step();
            chk(rdy_out == (k < LAT), "R7 rdy fall latency", 32'(rdy_out), 32'(k < LAT));
        end
        chk(rx_valid == 1'b1, "R7 rx_valid", 32'(rx_valid), 1);
        chk(rx_data == b, "R7 rx_data", 32'(rx_data), 32'(b));
        pin_din = ~b;
        for (int k = 0; k < c; k++) begin
            step();
            chk(rdy_out == 1'b0 && rx_valid == 1'b1 && rx_data == b, "R8 back-pressure",
                {22'd0, rdy_out, rx_valid, rx_data}, {24'd1, b});
        end
        if (consume_first) begin
            rx_ready = 1'b1;
            step();
            rx_ready = 1'b0;
            chk(rx_valid == 1'b0, "R12 single delivery", 32'(rx_valid), 0);
            chk(rdy_out == 1'b0, "R9 rdy waits for dav", 32'(rdy_out), 0);
            step();
            chk(rdy_out == 1'b0, "R9 rdy waits for dav", 32'(rdy_out), 0);
            dav_n_in = 1'b1;
            for (int k = 1; k <= LAT; k++) begin
                step();
                chk(rdy_out == (k == LAT), "R9 rdy rise latency", 32'(rdy_out), 32'(k == LAT));
            end
        end else begin
            dav_n_in = 1'b1;
            for (int k = 0; k < LAT + 2; k++) step();
            chk(rdy_out == 1'b0 && rx_valid == 1'b1, "R8 rdy low until taken",
                {30'd0, rdy_out, rx_valid}, 32'd1);
            rx_ready = 1'b1;
            step();
            rx_ready = 1'b0;
            chk(rx_valid == 1'b0, "R12 single delivery", 32'(rx_valid), 0);
            chk(rdy_out == 1'b1, "R9 rdy after take", 32'(rdy_out), 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1-through-R12 actual=timeout expected=done");
        report();
        $finish;
    end

    initial begin
        @(negedge clk);
        chk(dav_n_out == 1'b1 && rdy_out == 1'b1 && rx_valid == 1'b0, "R1 in reset",
            {29'd0, dav_n_out, rdy_out, rx_valid}, 32'd6);
        step();
        rst_n = 1'b1;
        step();
        chk(dav_n_out == 1'b1, "R1 dav after reset", 32'(dav_n_out), 1);
        chk(rdy_out == 1'b1, "R1 rdy after reset", 32'(rdy_out), 1);
        chk(rx_valid == 1'b0, "R1 rx_valid after reset", 32'(rx_valid), 0);
        chk(pin_oe == 1'b1, "R11 oe output", 32'(pin_oe), 1);

        for (int b = 0; b < 256; b++) out_xfer(8'(b), b % 4);

        // R10: dav_n_in ignored in output mode
        dav_n_in = 1'b0;
        for (int k = 0; k < LAT + 2; k++) begin
            step();
            chk(rx_valid == 1'b0 && rdy_out == 1'b1, "R10 output mode ignores dav",
                {30'd0, rx_valid, rdy_out}, 32'd1);
        end
        dav_n_in = 1'b1;
        for (int k = 0; k < LAT + 1; k++) step();

        dir_out = 1'b0;
        step();
        chk(pin_oe == 1'b0, "R11 oe input", 32'(pin_oe), 0);
        tx_valid = 1'b1;
        tx_data  = 8'hA5;
        for (int k = 0; k < 3; k++) begin
            step();
            chk(tx_ready == 1'b0 && dav_n_out == 1'b1, "R10 input mode ignores tx",
                {30'd0, tx_ready, dav_n_out}, 32'd1);
        end
        tx_valid = 1'b0;
        rdy_in = 1'b0;
        for (int k = 0; k < LAT + 1; k++) begin
            step();
            chk(dav_n_out == 1'b1, "R10 input mode ignores rdy_in", 32'(dav_n_out), 1);
        end
        rdy_in = 1'b1;
        for (int k = 0; k < LAT + 1; k++) step();

        for (int b = 0; b < 256; b++) in_xfer(8'(b), b % 3, b[0]);

        report();
        $finish;
    end
endmodule